// File: doc/BRIEF.md
# Low-power event timer with compare

This block is a 16-bit up-counter with a comparator, reached through a small memory-mapped register port. The counter advances on every clock of the timer domain, or on rising, falling or both edges of one trigger line. That line is chosen from a set of sixteen external inputs and passes through a two-flop synchronizer. The counter and the comparator are never addressed directly. Software stages a value in a shared DATA register and then writes self-clearing command bits that move that value into the counter or the comparator, or copy either of them back into DATA.

A counter wrap from all-ones to zero is an overflow event. A counting step taken while the counter equals the comparator is a compare event. Each event sets a sticky status flag, can toggle the timer output pin, and can raise the interrupt. A compare event can optionally send the counter back to zero, which gives a programmable period of comparator+1 steps. Counting stops when the run bit is clear. When the freeze bit is set, it also stops while the debug-halt input is high.

The register port is a valid/ready request channel plus a valid/ready read-response channel. A request is taken on a clock where `req_valid` and `req_ready` are both high. A read returns its data on `rsp_valid` one clock later and holds it until `rsp_ready` is seen. While a response is stalled, `req_ready` stays low, so at most one response is ever outstanding.

Top module: `lpt_event_timer`

## Requirements
- R1: After reset, CONTROL, DATA, STATUS, the counter and the comparator are 0, and `irq`, `tmr_out` and `rsp_valid` are low.
- R2: Addresses are: CONTROL 0x00 with a write-one-to-set alias at 0x04 and a write-one-to-clear alias at 0x08; DATA 0x10, using bits 15:0; STATUS 0x20 with set alias 0x24 and clear alias 0x28. The aliases and unmapped addresses read as 0.
- R3: In a write to CONTROL or its set alias, bit 8 loads DATA into the counter and bit 9 copies the counter into DATA. Bit 10 loads DATA into the comparator and bit 11 copies the comparator into DATA. Each takes effect on the accepting clock, and all four bits read back as 0.
- R4: With count mode bits 1:0 = 0 and run bit 31 set, the counter advances by one on every clock.
- R5: Count modes 1, 2 and 3 advance the counter on rising, falling or both edges of the trigger input chosen by CONTROL bits 7:4. The input is synchronized by two flops. Trigger inputs that are not selected have no effect.
- R6: A counting step from 0xFFFF gives 0x0000 and sets STATUS bit 0.
- R7: A counting step taken while the counter equals the comparator sets STATUS bit 1. With CONTROL bit 24 set, that step loads 0; otherwise the counter keeps incrementing.
- R8: With run bit 31 clear, the counter holds its value and no compare or overflow event occurs.
- R9: With CONTROL bit 30 set, a high `dbg_halt` freezes counting. With bit 30 clear, `dbg_halt` is ignored.
- R10: STATUS flags stay set until software clears them, through the clear alias or a direct write of 0. A hardware event wins over a software clear in the same clock.
- R11: `irq` is high while STATUS bit 0 with CONTROL bit 16 set, or STATUS bit 1 with CONTROL bit 17 set.
- R12: `tmr_out` toggles on each overflow when CONTROL bit 18 is set, and on each compare event when CONTROL bit 19 is set.
- R13: A read response held with `rsp_ready` low keeps `rsp_valid` high and `rsp_data` unchanged, and holds `req_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 32 | Read response data |
| trig_in | input | 16 | External trigger inputs |
| dbg_halt | input | 1 | Debug halt request |
| tmr_out | output | 1 | Toggling timer output |
| irq | output | 1 | Interrupt request |

## Verification
The counting function is exercised in free mode over a known number of clocks. It is also exercised with trains of pulses on the selected trigger, with pulses on an unselected line in between, in each of the three edge modes. Free mode shows the exact count per clock. The rising, falling and both-edge runs separate the edge polarities, giving 3, 3 and 6 for the same three pulses, and show that the select field isolates the chosen line. Runs that cross 0xFFFF, and runs that pass the compare value with and without reset-on-compare, separate the wrap from the compare reload through the captured counter value, the flags and the output toggles. Runs with debug halt asserted separate the freeze enable from the halt input.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_CTRL     = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTRL_SET = 6'h04;
  localparam logic [ADDR_W-1:0] A_CTRL_CLR = 6'h08;
  localparam logic [ADDR_W-1:0] A_DATA     = 6'h10;
  localparam logic [ADDR_W-1:0] A_STAT     = 6'h20;
  localparam logic [ADDR_W-1:0] A_STAT_SET = 6'h24;
  localparam logic [ADDR_W-1:0] A_STAT_CLR = 6'h28;

  // control field positions
  localparam int B_SEL_LO  = 4;
  localparam int B_LDCNT   = 8;
  localparam int B_CAPCNT  = 9;
  localparam int B_LDCMP   = 10;
  localparam int B_CAPCMP  = 11;
  localparam int B_OVF_IE  = 16;
  localparam int B_CMP_IE  = 17;
  localparam int B_OVF_TGL = 18;
  localparam int B_CMP_TGL = 19;
  localparam int B_CMP_RST = 24;
  localparam int B_DBG_FRZ = 30;
  localparam int B_RUN     = 31;

  // bits that hold state in CONTROL; command bits and reserved bits excluded
  localparam logic [BUS_W-1:0] CTRL_KEEP = 32'hC10F_00F3;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_RISE = 2'd1,
    MODE_FALL = 2'd2,
    MODE_BOTH = 2'd3
  } cnt_mode_e;

endpackage

// File: rtl/lpt_trig_edge.sv
module lpt_trig_edge
  import lpt_pkg::*;
#(
  parameter int NUM_TRIG    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    sel,
  input  cnt_mode_e           mode,
  output logic                tick
);

  logic                   raw;
  logic [SYNC_STAGES:0]   sh;
  logic                   cur, prev;

  assign raw  = trig_in[sel];
  assign cur  = sh[SYNC_STAGES-1];
  assign prev = sh[SYNC_STAGES];

  // synchronizer stages followed by one history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], raw};
  end

  always_comb begin
    unique case (mode)
      MODE_FREE: tick = 1'b1;
      MODE_RISE: tick = cur & ~prev;
      MODE_FALL: tick = ~cur & prev;
      default:   tick = cur ^ prev;
    endcase
  end

endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             ld_cnt,
  input  logic             ld_cmp,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             hit_clears,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             wrap_evt,
  output logic             hit_evt
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  assign wrap_evt = step && (cnt == ALL_ONES);
  assign hit_evt  = step && (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ld_cnt) begin
      cnt <= ld_val;
    end else if (step) begin
      cnt <= (hit_evt && hit_clears) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp <= '0;
    else if (ld_cmp) cmp <= ld_val;
  end

endmodule

// File: rtl/lpt_event_timer.sv
module lpt_event_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_TRIG    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BUS_W-1:0]    req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [BUS_W-1:0]    rsp_data,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                dbg_halt,
  output logic                tmr_out,
  output logic                irq
);

  localparam int SEL_W = $clog2(NUM_TRIG);

  logic [BUS_W-1:0] ctrl_q, ctrl_nxt;
  logic [CNT_W-1:0] data_q;
  logic [1:0]       status_q, status_sw;
  logic [CNT_W-1:0] cnt, cmp;
  logic             wr_acc, rd_acc;
  logic             wr_ctrl, wr_ctrl_set, wr_ctrl_clr, wr_data;
  logic             wr_stat, wr_stat_set, wr_stat_clr;
  logic             ctrl_wr, st_wr;
  logic [3:0]       cmd;
  logic             run_eff, tick, step;
  logic             ovf_evt, cmp_evt;
  logic [BUS_W-1:0] rd_mux;

  // request channel
  assign req_ready = !rsp_valid || rsp_ready;
  assign wr_acc    = req_valid && req_ready && req_write;
  assign rd_acc    = req_valid && req_ready && !req_write;

  assign wr_ctrl     = wr_acc && (req_addr == A_CTRL);
  assign wr_ctrl_set = wr_acc && (req_addr == A_CTRL_SET);
  assign wr_ctrl_clr = wr_acc && (req_addr == A_CTRL_CLR);
  assign wr_data     = wr_acc && (req_addr == A_DATA);
  assign wr_stat     = wr_acc && (req_addr == A_STAT);
  assign wr_stat_set = wr_acc && (req_addr == A_STAT_SET);
  assign wr_stat_clr = wr_acc && (req_addr == A_STAT_CLR);
  assign ctrl_wr     = wr_ctrl || wr_ctrl_set || wr_ctrl_clr;
  assign st_wr       = wr_stat || wr_stat_set || wr_stat_clr;

  // command pulses: {cap_cmp, ld_cmp, cap_cnt, ld_cnt}
  assign cmd = (wr_ctrl || wr_ctrl_set) ? req_wdata[B_CAPCMP:B_LDCNT] : 4'b0000;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_ctrl)          ctrl_nxt = req_wdata & CTRL_KEEP;
    else if (wr_ctrl_set) ctrl_nxt = ctrl_q | (req_wdata & CTRL_KEEP);
    else if (wr_ctrl_clr) ctrl_nxt = ctrl_q & ~req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end

  // shared staging register; counter capture ranks above comparator capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cmd[1]) data_q <= cnt;
    else if (cmd[3]) data_q <= cmp;
    else if (wr_data) data_q <= req_wdata[CNT_W-1:0];
  end

  // counting core
  assign run_eff = ctrl_q[B_RUN] && !(ctrl_q[B_DBG_FRZ] && dbg_halt);
  assign step    = run_eff && tick;

  lpt_trig_edge #(
    .NUM_TRIG   (NUM_TRIG),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_in(trig_in),
    .sel    (ctrl_q[B_SEL_LO +: SEL_W]),
    .mode   (cnt_mode_e'(ctrl_q[1:0])),
    .tick   (tick)
  );

  lpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .ld_cnt    (cmd[0]),
    .ld_cmp    (cmd[2]),
    .ld_val    (data_q),
    .hit_clears(ctrl_q[B_CMP_RST]),
    .cnt       (cnt),
    .cmp       (cmp),
    .wrap_evt  (ovf_evt),
    .hit_evt   (cmp_evt)
  );

  // status flags: software update first, hardware events override
  always_comb begin
    status_sw = status_q;
    if (wr_stat)          status_sw = req_wdata[1:0];
    else if (wr_stat_set) status_sw = status_q | req_wdata[1:0];
    else if (wr_stat_clr) status_sw = status_q & ~req_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_sw | {cmp_evt, ovf_evt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_out <= 1'b0;
    else        tmr_out <= tmr_out ^ (ovf_evt && ctrl_q[B_OVF_TGL])
                                   ^ (cmp_evt && ctrl_q[B_CMP_TGL]);
  end

  assign irq = (status_q[0] && ctrl_q[B_OVF_IE]) || (status_q[1] && ctrl_q[B_CMP_IE]);

  // read response channel
  always_comb begin
    unique case (req_addr)
      A_CTRL:  rd_mux = ctrl_q;
      A_DATA:  rd_mux = {{(BUS_W-CNT_W){1'b0}}, data_q};
      A_STAT:  rd_mux = {{(BUS_W-2){1'b0}}, status_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/lpt_event_timer_chk.sv
module lpt_event_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_data,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             step,
  input logic             ld_cnt,
  input logic             hit_clears,
  input logic             ovf_evt,
  input logic             cmp_evt,
  input logic             ovf_ie,
  input logic             ctrl_wr,
  input logic             st_wr,
  input logic [1:0]       status_q,
  input logic             tmr_out,
  input logic             irq
);

  assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (cnt == {CNT_W{1'b1}}) && !ld_cnt) |=> (cnt == '0));

  assert_cmp_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (cnt == cmp) && hit_clears && !ld_cnt) |=> (cnt == '0));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_cnt) |=> $stable(cnt));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && !st_wr) |=> status_q[0]);

  assert_cmp_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[1] && !st_wr) |=> status_q[1]);

  assert_ovf_raises_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && ovf_ie && !st_wr && !ctrl_wr) |=> irq);

  assert_out_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_evt && !cmp_evt) |=> $stable(tmr_out));

  assert_rsp_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

endmodule

bind lpt_event_timer lpt_event_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .cnt       (cnt),
  .cmp       (cmp),
  .step      (step),
  .ld_cnt    (cmd[0]),
  .hit_clears(ctrl_q[24]),
  .ovf_evt   (ovf_evt),
  .cmp_evt   (cmp_evt),
  .ovf_ie    (ctrl_q[16]),
  .ctrl_wr   (ctrl_wr),
  .st_wr     (st_wr),
  .status_q  (status_q),
  .tmr_out   (tmr_out),
  .irq       (irq)
);

// File: tb/tb_lpt_event_timer.sv
`timescale 1ns/1ps
module tb_lpt_event_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [15:0] trig_in = '0;
  logic        dbg_halt = 1'b0;
  logic        tmr_out;
  logic        irq;

  always #2.5 clk = ~clk;

  lpt_event_timer dut (.*);

  int          n_checks = 0;
  int          n_fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // scoreboard monitor: compares each read response against the queue
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          n_checks++;
          n_fails++;
          $display("FAIL R2 unexpected response actual=%h expected=none", rsp_data);
        end else begin
          check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
        end
      end
    end
  end

  task automatic bus(input logic wr, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus(1'b1, a, d);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(1'b0, a, 32'h0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int b);
    @(negedge clk); trig_in[b] = 1'b1;
    idle(4);
    trig_in[b] = 1'b0;
    idle(4);
  endtask

  // reload the counter with v and leave CONTROL at 0
  task automatic load_cnt(input logic [15:0] v);
    wr(6'h10, {16'h0, v});
    wr(6'h00, 32'h0000_0100);
  endtask

  task automatic cap_cnt(input logic [15:0] exp, input string tag);
    wr(6'h04, 32'h0000_0200);
    rd(6'h10, {16'h0, exp}, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    logic        out_exp;
    out_exp = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 tmr_out", {31'h0, tmr_out}, 32'h0);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rd(6'h00, 32'h0, "R1 control");
    rd(6'h10, 32'h0, "R1 data");
    rd(6'h20, 32'h0, "R1 status");
    wr(6'h04, 32'h0000_0800);
    rd(6'h10, 32'h0, "R1 comparator");

    // R2 aliases and unmapped read 0; R3 command bits read back 0
    wr(6'h00, 32'h0001_0F00);
    rd(6'h00, 32'h0001_0000, "R3 self-clear");
    rd(6'h04, 32'h0, "R2 set alias reads 0");
    rd(6'h28, 32'h0, "R2 clear alias reads 0");
    rd(6'h30, 32'h0, "R2 unmapped");
    wr(6'h10, 32'hABCD_1234);
    rd(6'h10, 32'h0000_1234, "R2 data width");

    // R4 free running: 10 idle clocks between start and stop -> 12 steps
    load_cnt(16'd100);
    wr(6'h00, 32'h8000_0000);
    idle(10);
    wr(6'h08, 32'h8000_0000);
    cap_cnt(16'd112, "R4 free count");
    idle(6);
    cap_cnt(16'd112, "R8 stopped counter holds");

    // R6 overflow, R11 irq, R12 overflow toggle, R3 comparator copy
    load_cnt(16'hFFFE);
    wr(6'h10, 32'h0000_8000);
    wr(6'h00, 32'h0000_0400);
    wr(6'h00, 32'h8005_0000);
    wr(6'h08, 32'h8000_0000);
    out_exp = ~out_exp;
    check("R11 irq on overflow", {31'h0, irq}, 32'h1);
    check("R12 overflow toggle", {31'h0, tmr_out}, {31'h0, out_exp});
    rd(6'h20, 32'h1, "R6 overflow flag");
    cap_cnt(16'h0000, "R6 wrap to zero");
    wr(6'h04, 32'h0000_0800);
    rd(6'h10, 32'h0000_8000, "R3 comparator copy");
    wr(6'h28, 32'h1);
    check("R11 irq drops", {31'h0, irq}, 32'h0);
    rd(6'h20, 32'h0, "R10 clear alias");

    // R7 compare with reload: cmp=4, 7 steps -> 0,1,2,3,4,0,1,2
    load_cnt(16'd0);
    wr(6'h10, 32'd4);
    wr(6'h00, 32'h0000_0400);
    wr(6'h00, 32'h810A_0000);
    idle(5);
    wr(6'h08, 32'h8000_0000);
    out_exp = ~out_exp;
    check("R12 compare toggle", {31'h0, tmr_out}, {31'h0, out_exp});
    check("R11 irq on compare", {31'h0, irq}, 32'h1);
    rd(6'h20, 32'h2, "R7 compare flag");
    cap_cnt(16'd2, "R7 reload on compare");

    // R7 compare without reload: cmp=1, 3 steps -> 3
    wr(6'h28, 32'h3);
    load_cnt(16'd0);
    wr(6'h10, 32'd1);
    wr(6'h00, 32'h0000_0400);
    wr(6'h00, 32'h8002_0000);
    idle(1);
    wr(6'h08, 32'h8000_0000);
    rd(6'h20, 32'h2, "R7 flag without reload");
    cap_cnt(16'd3, "R7 keeps counting");

    // R8 stopped with counter == comparator: no event
    wr(6'h10, 32'd3);
    wr(6'h04, 32'h0000_0400);
    wr(6'h28, 32'h3);
    idle(6);
    rd(6'h20, 32'h0, "R8 no compare when stopped");

    // R5 rising, falling, both on trigger 5; trigger 2 pulses ignored
    load_cnt(16'd0);
    wr(6'h00, 32'h8000_0051);
    pulse(5); pulse(2); pulse(5); pulse(2); pulse(5);
    wr(6'h08, 32'h8000_0000);
    cap_cnt(16'd3, "R5 rising edges");
    load_cnt(16'd0);
    wr(6'h00, 32'h8000_0052);
    pulse(5); pulse(2); pulse(5); pulse(5);
    wr(6'h08, 32'h8000_0000);
    cap_cnt(16'd3, "R5 falling edges");
    load_cnt(16'd0);
    wr(6'h00, 32'h8000_0053);
    pulse(5); pulse(2); pulse(5); pulse(5);
    wr(6'h08, 32'h8000_0000);
    cap_cnt(16'd6, "R5 both edges");

    // R9 debug freeze
    load_cnt(16'd50);
    dbg_halt = 1'b1;
    wr(6'h00, 32'hC000_0000);
    idle(3);
    wr(6'h08, 32'h8000_0000);
    cap_cnt(16'd50, "R9 frozen in halt");
    wr(6'h00, 32'h8000_0000);
    idle(3);
    wr(6'h08, 32'h8000_0000);
    cap_cnt(16'd55, "R9 halt ignored");
    dbg_halt = 1'b0;

    // R10 set/clear/direct, R11 compare enable
    wr(6'h00, 32'h0002_0000);
    wr(6'h24, 32'h2);
    check("R11 irq from set flag", {31'h0, irq}, 32'h1);
    rd(6'h20, 32'h2, "R10 set alias");
    wr(6'h20, 32'h1);
    check("R11 irq gated by enable", {31'h0, irq}, 32'h0);
    rd(6'h20, 32'h1, "R10 direct write");
    wr(6'h28, 32'h1);
    rd(6'h20, 32'h0, "R10 cleared");

    // R13 back-pressure on the response
    wr(6'h10, 32'h0000_5A5A);
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(6'h10, 32'h0000_5A5A, "R13 released data");
    #1;
    held = rsp_data;
    for (int i = 0; i < 3; i++) begin
      check("R13 valid held", {31'h0, rsp_valid}, 32'h1);
      check("R13 request stalled", {31'h0, req_ready}, 32'h0);
      check("R13 data stable", rsp_data, held);
      @(negedge clk); #1;
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    idle(4);

    check("R2 all responses seen", exp_q.size(), 32'h0);
    finish_run();
  end

endmodule